// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a system watchdog with a 12-bit down-counter that steps once per slow tick enable (256 ticks per second gives about 16 s at the full count of 0xFFF). Software must restart it before it underflows, but not too early: a restart is accepted only when the counter has fallen to or below a programmed window value. A restart issued above the window, and an underflow, both count as faults. A fault can pulse a reset output, raise an interrupt level, or both.

Three word registers sit on a single-cycle read/write strobe bus. The control register takes keyed restart commands. The mode register holds the reload value, the window value, the fault actions, a full disable and two halt qualifiers, and it locks after its first write. The status register reports the fault cause and the live count, and reading it clears the fault flags. Once running, the counter can only be stopped by the single mode write that sets the disable bit.

Top module: `win_watchdog`

## Requirements
- R1: After reset the mode register (byte offset 0x4, bits 29:0) reads 0x3FFF2FFF, the status register (offset 0x8) reads 0x0FFF0000, and the interrupt and both reset outputs are low.
- R2: While enabled and not halted, each cycle with `tick_en` high lowers the count by one. The count is visible in status bits 27:16.
- R3: The first mode write after reset is stored and loads the counter from its reload field, bits 11:0. Every later mode write is ignored and changes neither the register nor the count.
- R4: A control write (offset 0x0) with 0xA5 in bits 31:24 and bit 0 set reloads the counter when the count is at or below the window field (mode bits 27:16). This includes the case where the count equals the window.
- R5: The same restart issued while the count is above the window leaves the count unchanged, sets status bit 1 and counts as a fault.
- R6: A control write with any other key, or without bit 0, has no effect.
- R7: A tick at count zero is an underflow: the counter reloads from the reload field, status bit 0 is set, and the event counts as a fault.
- R8: A status read returns the flags and count as they were before that cycle and then clears both flags. A fault in the same cycle as the read leaves its flag set.
- R9: If mode bit 13 is set, each fault gives a one-cycle pulse. The pulse goes on `wd_rst_cpu` when mode bit 14 is set and on `wd_rst_sys` otherwise.
- R10: `wd_irq` is high while mode bit 12 is set and either status flag is set.
- R11: The count holds while `halt_idle` is high with mode bit 29 set, or while `halt_dbg` is high with mode bit 28 set.
- R12: With mode bit 15 set, the counter is frozen and restarts cause neither reloads nor faults.
- R13: A valid restart in the same cycle as a tick at count zero reloads the counter and suppresses the underflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow count enable, one cycle per tick |
| halt_idle | input | 1 | System idle indication |
| halt_dbg | input | 1 | Debugger halt indication |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address, bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| wd_irq | output | 1 | Fault interrupt level |
| wd_rst_sys | output | 1 | Full-system reset pulse |
| wd_rst_cpu | output | 1 | Processor-only reset pulse |

## Verification
Two pairs of functions can land on the same clock edge. In the first pair, an underflow can coincide with the clear-on-read of the status register. The bench counts the timer down to zero and then drives a tick and a status read in one cycle. It expects the read to return the pre-edge value with the flags clear, and a second read to show the underflow flag still set. In the second pair, a valid restart can coincide with the underflow tick. The bench drives both in one cycle and expects a reload to the reload value, no flag and no reset pulse.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int CNT_W  = 12;
  localparam int MODE_W = 30;

  typedef struct packed {
    logic             halt_idle;  // 29
    logic             halt_dbg;   // 28
    logic [CNT_W-1:0] window;     // 27:16
    logic             dis;        // 15
    logic             proc_only;  // 14
    logic             rst_en;     // 13
    logic             irq_en;     // 12
    logic [CNT_W-1:0] reload;     // 11:0
  } mode_t;

  localparam mode_t MODE_RST = mode_t'(30'h3FFF2FFF);

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MODE = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int STAT_CNT_LSB = 16;
  localparam int KEY_LSB      = 24;
  localparam int KEY_W        = 8;
endpackage

// File: rtl/wdw_regs.sv
module wdw_regs
  import wdw_pkg::*;
#(
  parameter int              ADDR_W = 4,
  parameter int              DATA_W = 32,
  parameter logic [KEY_W-1:0] KEY   = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              uf_evt,
  input  logic              win_evt,
  output mode_t             mode,
  output logic              mode_load,
  output logic              restart_req,
  output logic [1:0]        flags,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              wr_hit, rd_hit, stat_rd;
  reg_sel_e          sel;
  logic              locked_q, locked_d;
  mode_t             mode_q, mode_d;
  logic [1:0]        flags_q, flags_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] stat_word, mode_word;

  assign sel     = reg_sel_e'(bus_addr[3:2]);
  assign wr_hit  = bus_sel & bus_wr;
  assign rd_hit  = bus_sel & ~bus_wr;
  assign stat_rd = rd_hit & (sel == SEL_STAT);

  assign mode_load   = wr_hit & (sel == SEL_MODE) & ~locked_q;
  assign restart_req = wr_hit & (sel == SEL_CTRL) &
                       (bus_wdata[KEY_LSB +: KEY_W] == KEY) & bus_wdata[0];

  always_comb begin
    stat_word = '0;
    stat_word[1:0] = flags_q;
    stat_word[STAT_CNT_LSB +: CNT_W] = cnt;
    mode_word = '0;
    mode_word[MODE_W-1:0] = mode_q;
  end

  always_comb begin
    locked_d = locked_q | mode_load;
    mode_d   = mode_load ? mode_t'(bus_wdata[MODE_W-1:0]) : mode_q;
    // a new event wins over the clear of the same cycle
    flags_d[0] = (flags_q[0] & ~stat_rd) | uf_evt;
    flags_d[1] = (flags_q[1] & ~stat_rd) | win_evt;
    rdata_d = rdata_q;
    if (rd_hit) begin
      case (sel)
        SEL_MODE: rdata_d = mode_word;
        SEL_STAT: rdata_d = stat_word;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      mode_q   <= MODE_RST;
      flags_q  <= 2'b00;
      rdata_q  <= '0;
    end else begin
      locked_q <= locked_d;
      mode_q   <= mode_d;
      flags_q  <= flags_d;
      rdata_q  <= rdata_d;
    end
  end

  assign mode      = mode_q;
  assign flags     = flags_q;
  assign bus_rdata = rdata_q;

  // R3: once locked the mode register never changes
  p_mode_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mode_q));

  // R8: a flag is only dropped by a status read
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != 2'b00 && !stat_rd) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
  import wdw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             halt_idle,
  input  logic             halt_dbg,
  input  mode_t            mode,
  input  logic             mode_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             restart_req,
  output logic [CNT_W-1:0] cnt,
  output logic             uf_evt,
  output logic             win_evt
);
  logic             active, halted, step, in_window, ok_restart, at_zero;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign active     = ~mode.dis;
  assign halted     = (halt_idle & mode.halt_idle) | (halt_dbg & mode.halt_dbg);
  assign step       = tick_en & active & ~halted;
  assign in_window  = (cnt_q <= mode.window);
  assign at_zero    = (cnt_q == '0);
  assign ok_restart = restart_req & active & in_window;
  assign win_evt    = restart_req & active & ~in_window;
  assign uf_evt     = step & at_zero & ~ok_restart & ~mode_load;

  always_comb begin
    cnt_d = cnt_q;
    if (mode_load)       cnt_d = load_val;
    else if (ok_restart) cnt_d = mode.reload;
    else if (step)       cnt_d = at_zero ? mode.reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= MODE_RST.reload;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2: a plain tick lowers the count by exactly one
  p_tick_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero && !restart_req && !mode_load) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R3: the count never exceeds the stored reload value
  p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= mode.reload);

  // R5: an early restart without a tick leaves the count alone
  p_early_no_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_evt && !tick_en) |=> $stable(cnt_q));

  // R12: a disabled watchdog is frozen
  p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.dis && !mode_load) |=> $stable(cnt_q));

  // R11: halted counting keeps the count unless a restart or load intervenes
  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart_req && !mode_load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdw_fault.sv
module wdw_fault
  import wdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uf_evt,
  input  logic       win_evt,
  input  mode_t      mode,
  input  logic [1:0] flags,
  output logic       irq,
  output logic       rst_sys,
  output logic       rst_cpu
);
  logic fault;
  logic sys_q, sys_d, cpu_q, cpu_d;

  assign fault = uf_evt | win_evt;

  always_comb begin
    sys_d = fault & mode.rst_en & ~mode.proc_only;
    cpu_d = fault & mode.rst_en &  mode.proc_only;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q <= 1'b0;
      cpu_q <= 1'b0;
    end else begin
      sys_q <= sys_d;
      cpu_q <= cpu_d;
    end
  end

  assign rst_sys = sys_q;
  assign rst_cpu = cpu_q;
  assign irq     = mode.irq_en & (|flags);

  // R9: at most one reset target pulses at a time
  p_rst_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_sys, rst_cpu}));

  // R9: an enabled fault is followed by a pulse on one target
  p_rst_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && mode.rst_en) |=> (rst_sys || rst_cpu));

  // R10: a raised flag with interrupts enabled shows on the interrupt line
  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && mode.irq_en) |=> irq);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdw_pkg::*;
#(
  parameter int               ADDR_W      = 4,
  parameter int               DATA_W      = 32,
  parameter logic [KEY_W-1:0] KEY         = 8'hA5,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              halt_idle,
  input  logic              halt_dbg,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_irq,
  output logic              wd_rst_sys,
  output logic              wd_rst_cpu
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   rst_int_n;
  mode_t                  mode;
  logic                   mode_load, restart_req, uf_evt, win_evt;
  logic [1:0]             flags;
  logic [CNT_W-1:0]       cnt;

  // asynchronous assert, synchronous release
  always_comb sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[SYNC_STAGES-1];

  wdw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cnt        (cnt),
    .uf_evt     (uf_evt),
    .win_evt    (win_evt),
    .mode       (mode),
    .mode_load  (mode_load),
    .restart_req(restart_req),
    .flags      (flags),
    .bus_rdata  (bus_rdata)
  );

  wdw_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick_en    (tick_en),
    .halt_idle  (halt_idle),
    .halt_dbg   (halt_dbg),
    .mode       (mode),
    .mode_load  (mode_load),
    .load_val   (bus_wdata[CNT_W-1:0]),
    .restart_req(restart_req),
    .cnt        (cnt),
    .uf_evt     (uf_evt),
    .win_evt    (win_evt)
  );

  wdw_fault u_fault (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .uf_evt (uf_evt),
    .win_evt(win_evt),
    .mode   (mode),
    .flags  (flags),
    .irq    (wd_irq),
    .rst_sys(wd_rst_sys),
    .rst_cpu(wd_rst_cpu)
  );
endmodule

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, halt_idle, halt_dbg, bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        wd_irq, wd_rst_sys, wd_rst_cpu;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  win_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt_idle(halt_idle),
    .halt_dbg(halt_dbg), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_irq(wd_irq), .wd_rst_sys(wd_rst_sys), .wd_rst_cpu(wd_rst_cpu)
  );

  // {kind, addr, data, expected, req}; kind 0 tick, 1 write, 2 read
  localparam int NV = 20;
  localparam logic [73:0] VEC [NV] = '{
    {2'd2, 4'h4, 32'h0,        32'h3FFF2FFF, 4'd1},  // R1 mode reset value
    {2'd2, 4'h8, 32'h0,        32'h0FFF0000, 4'd1},  // R1 status reset value
    {2'd0, 4'h0, 32'h0,        32'h0,        4'd2},
    {2'd0, 4'h0, 32'h0,        32'h0,        4'd2},
    {2'd0, 4'h0, 32'h0,        32'h0,        4'd2},
    {2'd2, 4'h8, 32'h0,        32'h0FFC0000, 4'd2},  // R2 three ticks
    {2'd1, 4'h0, 32'hA5000001, 32'h0,        4'd4},
    {2'd2, 4'h8, 32'h0,        32'h0FFF0000, 4'd4},  // R4 restart reloads
    {2'd0, 4'h0, 32'h0,        32'h0,        4'd6},
    {2'd1, 4'h0, 32'h5A000001, 32'h0,        4'd6},  // R6 wrong key
    {2'd1, 4'h0, 32'hA5000000, 32'h0,        4'd6},  // R6 no restart bit
    {2'd2, 4'h8, 32'h0,        32'h0FFE0000, 4'd6},
    {2'd1, 4'h4, 32'h30083010, 32'h0,        4'd3},
    {2'd2, 4'h4, 32'h0,        32'h30083010, 4'd3},  // R3 first write stored
    {2'd1, 4'h4, 32'h00000FFF, 32'h0,        4'd3},
    {2'd2, 4'h4, 32'h0,        32'h30083010, 4'd3},  // R3 second write ignored
    {2'd2, 4'h8, 32'h0,        32'h00100000, 4'd3},
    {2'd1, 4'h0, 32'hA5000001, 32'h0,        4'd5},  // R5 early restart
    {2'd2, 4'h8, 32'h0,        32'h00100002, 4'd5},
    {2'd2, 4'h8, 32'h0,        32'h00100000, 4'd8}   // R8 flags cleared
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; tick_en = 1'b0; halt_idle = 1'b0; halt_dbg = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();
    chk("R1 outputs", {29'd0, wd_irq, wd_rst_sys, wd_rst_cpu}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][73:72])
        2'd0: do_tick();
        2'd1: bus_write(VEC[i][71:68], VEC[i][67:36]);
        default: begin
          bus_read(VEC[i][71:68], rd);
          chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
        end
      endcase
    end

    // R9 R10: early restart gives one system pulse and the interrupt
    bus_write(4'h0, 32'hA5000001);
    chk("R9 sys pulse", {31'd0, wd_rst_sys}, 32'd1);
    chk("R9 cpu quiet", {31'd0, wd_rst_cpu}, 32'd0);
    chk("R10 irq set", {31'd0, wd_irq}, 32'd1);
    @(negedge clk);
    chk("R9 one cycle", {31'd0, wd_rst_sys}, 32'd0);
    bus_read(4'h8, rd);
    chk("R5 flag again", rd, 32'h00100002);
    chk("R10 irq cleared", {31'd0, wd_irq}, 32'd0);

    // R7: underflow
    ticks(16);
    bus_read(4'h8, rd);
    chk("R2 at zero", rd, 32'h00000000);
    do_tick();
    chk("R7 reset pulse", {31'd0, wd_rst_sys}, 32'd1);
    bus_read(4'h8, rd);
    chk("R7 underflow", rd, 32'h00100001);

    // R11: halts
    halt_idle = 1'b1; ticks(3);
    bus_read(4'h8, rd);
    chk("R11 idle halt", rd, 32'h00100000);
    halt_idle = 1'b0; halt_dbg = 1'b1; ticks(2);
    bus_read(4'h8, rd);
    chk("R11 dbg halt", rd, 32'h00100000);
    halt_dbg = 1'b0; do_tick();
    bus_read(4'h8, rd);
    chk("R2 resume", rd, 32'h000F0000);

    // R4: restart exactly at the window value
    ticks(7);
    bus_write(4'h0, 32'hA5000001);
    chk("R4 no fault at edge", {31'd0, wd_rst_sys}, 32'd0);
    bus_read(4'h8, rd);
    chk("R4 edge reload", rd, 32'h00100000);

    // R13: restart together with underflow tick
    ticks(16);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'hA5000001;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R13 no pulse", {31'd0, wd_rst_sys}, 32'd0);
    bus_read(4'h8, rd);
    chk("R13 reload no flag", rd, 32'h00100000);

    // R8: status read together with underflow
    ticks(16);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h8;
    @(negedge clk);
    rd = bus_rdata; tick_en = 1'b0; bus_sel = 1'b0;
    chk("R8 pre-edge value", rd, 32'h00000000);
    bus_read(4'h8, rd);
    chk("R8 flag survives", rd, 32'h00100001);

    // R12: disabled watchdog
    do_reset();
    chk("R1 outputs again", {29'd0, wd_irq, wd_rst_sys, wd_rst_cpu}, 32'd0);
    bus_write(4'h4, 32'h0000E005);
    ticks(10);
    bus_write(4'h0, 32'hA5000001);
    chk("R12 no pulse", {30'd0, wd_rst_sys, wd_rst_cpu}, 32'd0);
    bus_read(4'h8, rd);
    chk("R12 frozen", rd, 32'h00050000);

    // R9 R10: processor-only reset, interrupt disabled
    do_reset();
    bus_write(4'h4, 32'h00006002);
    ticks(3);
    chk("R9 cpu pulse", {31'd0, wd_rst_cpu}, 32'd1);
    chk("R9 sys quiet", {31'd0, wd_rst_sys}, 32'd0);
    chk("R10 irq off", {31'd0, wd_irq}, 32'd0);
    bus_read(4'h8, rd);
    chk("R7 flag no irq", rd, 32'h00020001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule